// File: doc/BRIEF.md
# Store-Buffered Shared Memory with Total Store Order

This block is a small shared memory that several requester ports use at once, with total-store-order semantics. Each port presents one command at a time on a valid/ready handshake. A command carries a 3-bit operation code, a word address and a data word. Stores do not go straight to memory. Each one lands in a private FIFO write buffer for its port. That buffer later retires its oldest entry into a register-array memory. Loads see the newest write from their own port's buffer before they see memory. Because of this, a port can observe its own stores before other ports can.

A single global lock lets one port hold everyone else off memory. Full fences wait for the port's buffer to drain. Load and store fences complete at once. Each cycle the block works out which ports' commands are eligible, then completes exactly one of them, chosen in round-robin order. A per-port drain-enable input decides when a buffer may retire entries. A test environment can use it to hold writes back and force reorderings, for example two cross-loads that both return the old values.

Top module: `tso_mem_sub`

## Requirements
- R1: After reset the memory reads zero at every address, the lock is free, every write buffer is empty, `rsp_valid_o` is low, and `cmd_ready_o` is low for every port whose valid is low.
- R2: A store (op 1) is accepted into the issuing port's buffer whenever that buffer is not full, whether or not the lock is held. It does not change memory, so another port's load still returns the older memory value.
- R3: A load (op 0) from a port returns the data of the newest entry in that port's own buffer whose address matches.
- R4: A load with no matching buffered entry returns the memory word. The response arrives with `rsp_valid_o` high for exactly one cycle, on the clock edge after the edge that accepts the load. `rsp_port_o` carries the issuing port's index.
- R5: A port's buffer retires entries oldest first, one per cycle, and only while its drain-enable is high and the port is unblocked. A port is unblocked when the lock is free or when it holds the lock.
- R6: A full fence (op 2) is accepted only once the issuing port's buffer is empty.
- R7: A load fence (op 3) or store fence (op 4) is accepted in the first cycle it is offered, if no other port is chosen in that cycle.
- R8: A lock request (op 5) is accepted only when the lock is free and the requester's buffer is empty, and the requester then owns the lock. While the lock is held, loads from any other port are not accepted.
- R9: An unlock request (op 6) is accepted only from the lock's owner with an empty buffer, and it frees the lock.
- R10: A store offered to a full buffer is held with ready low until an entry has drained.
- R11: At most one port's ready is high in a cycle, and only for a port whose valid is high. When several ports are eligible, the one granted most recently has the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | N_PORTS | Command valid per port |
| cmd_op_i | input | 3*N_PORTS | Operation code per port, 3 bits each |
| cmd_addr_i | input | AW*N_PORTS | Word address per port |
| cmd_data_i | input | DW*N_PORTS | Store data per port |
| cmd_ready_o | output | N_PORTS | Command accepted this cycle, per port |
| drain_en_i | input | N_PORTS | Allow a port's buffer to retire entries |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_port_o | output | IW | Index of the port the response belongs to |
| rsp_data_o | output | DW | Load data |

## Verification
The assertions assume that each port keeps its command fields steady while valid is high and that the operation code is one of the seven defined values. The bench drives every command from a single task that changes fields only on the falling edge and never offers the unused code 7. The bench then sweeps every address from every port through store, own-port forwarding, cross-port load, draining fence and cross-port load. It follows this with directed sequences that fill a buffer, hold a fence back, and take and release the lock while drains are pending.

// File: rtl/tso_pkg.sv
package tso_pkg;
  typedef enum logic [2:0] {
    OP_LD         = 3'd0,
    OP_ST         = 3'd1,
    OP_FULL_FENCE = 3'd2,
    OP_LD_FENCE   = 3'd3,
    OP_ST_FENCE   = 3'd4,
    OP_LOCK       = 3'd5,
    OP_UNLOCK     = 3'd6
  } op_e;
endpackage

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
  parameter int DEPTH = 2,
  parameter int AW    = 2,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] hd_addr_o,
  output logic [DW-1:0] hd_data_o,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] x);
    return (int'(x) == DEPTH - 1) ? '0 : x + 1'b1;
  endfunction

  assign full_o    = (int'(cnt_q) == DEPTH);
  assign empty_o   = (cnt_q == '0);
  assign hd_addr_o = addr_q[head_q];
  assign hd_data_o = data_q[head_q];

  // walk oldest to newest so the newest match wins
  always_comb begin
    int idx;
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = int'(head_q) + i;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (i < int'(cnt_q) && addr_q[idx] == lk_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end
endmodule

// File: rtl/tso_rr_arb.sv
module tso_rr_arb #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    int c;
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (!any_o && req_i[c]) begin
        any_o    = 1'b1;
        idx_o    = IW'(c);
        gnt_o[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N - 1);
    else if (any_o) last_q <= idx_o;
  end
endmodule

// File: rtl/tso_mem_sub.sv
module tso_mem_sub #(
  parameter int N_PORTS  = 2,
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int WB_DEPTH = 2,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_PORTS-1:0]    cmd_valid_i,
  input  logic [N_PORTS*3-1:0]  cmd_op_i,
  input  logic [N_PORTS*AW-1:0] cmd_addr_i,
  input  logic [N_PORTS*DW-1:0] cmd_data_i,
  output logic [N_PORTS-1:0]    cmd_ready_o,
  input  logic [N_PORTS-1:0]    drain_en_i,
  output logic                  rsp_valid_o,
  output logic [IW-1:0]         rsp_port_o,
  output logic [DW-1:0]         rsp_data_o
);
  localparam int NW = 1 << AW;

  tso_pkg::op_e  op    [N_PORTS];
  logic [AW-1:0] addr  [N_PORTS];
  logic [DW-1:0] wdata [N_PORTS];
  logic [AW-1:0] hd_addr  [N_PORTS];
  logic [DW-1:0] hd_data  [N_PORTS];
  logic [DW-1:0] hit_data [N_PORTS];
  logic [N_PORTS-1:0] unblk, elig, wb_full, wb_empty, wb_hit, push, drain;
  logic [DW-1:0] mem_q [NW];
  logic          lock_held_q;
  logic [IW-1:0] lock_owner_q;
  logic [IW-1:0] gidx;
  logic          gany, ld_fire;
  logic [DW-1:0] ld_data;

  always_comb begin
    logic ok;
    for (int p = 0; p < N_PORTS; p++) begin
      op[p]    = tso_pkg::op_e'(cmd_op_i[3*p +: 3]);
      addr[p]  = cmd_addr_i[AW*p +: AW];
      wdata[p] = cmd_data_i[DW*p +: DW];
      unblk[p] = !lock_held_q || (lock_owner_q == IW'(p));
      case (op[p])
        tso_pkg::OP_LD:         ok = unblk[p];
        tso_pkg::OP_ST:         ok = !wb_full[p];
        tso_pkg::OP_FULL_FENCE: ok = wb_empty[p];
        tso_pkg::OP_LD_FENCE,
        tso_pkg::OP_ST_FENCE:   ok = 1'b1;
        tso_pkg::OP_LOCK:       ok = !lock_held_q && wb_empty[p];
        tso_pkg::OP_UNLOCK:     ok = lock_held_q && (lock_owner_q == IW'(p)) && wb_empty[p];
        default:                ok = 1'b0;
      endcase
      elig[p]  = cmd_valid_i[p] && ok;
      push[p]  = cmd_ready_o[p] && (op[p] == tso_pkg::OP_ST);
      drain[p] = drain_en_i[p] && unblk[p] && !wb_empty[p];
    end
  end

  tso_rr_arb #(.N(N_PORTS), .IW(IW)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (elig),
    .gnt_o (cmd_ready_o),
    .idx_o (gidx),
    .any_o (gany)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_wb
    tso_wbuf #(.DEPTH(WB_DEPTH), .AW(AW), .DW(DW)) u_wb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push[g]),
      .push_addr_i(addr[g]),
      .push_data_i(wdata[g]),
      .pop_i      (drain[g]),
      .lk_addr_i  (addr[g]),
      .full_o     (wb_full[g]),
      .empty_o    (wb_empty[g]),
      .hd_addr_o  (hd_addr[g]),
      .hd_data_o  (hd_data[g]),
      .hit_o      (wb_hit[g]),
      .hit_data_o (hit_data[g])
    );
  end

  assign ld_fire = gany && (op[gidx] == tso_pkg::OP_LD);
  assign ld_data = wb_hit[gidx] ? hit_data[gidx] : mem_q[addr[gidx]];

  // same-address drains in one cycle: higher port index lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < N_PORTS; p++)
        if (drain[p]) mem_q[hd_addr[p]] <= hd_data[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_held_q  <= 1'b0;
      lock_owner_q <= '0;
    end else if (gany && op[gidx] == tso_pkg::OP_LOCK) begin
      lock_held_q  <= 1'b1;
      lock_owner_q <= gidx;
    end else if (gany && op[gidx] == tso_pkg::OP_UNLOCK) begin
      lock_held_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_port_o  <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= ld_fire;
      if (ld_fire) begin
        rsp_port_o <= gidx;
        rsp_data_o <= ld_data;
      end
    end
  end
endmodule

// File: rtl/tso_mem_chk.sv
module tso_mem_chk #(
  parameter int N_PORTS = 2,
  parameter int IW      = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_PORTS-1:0]   cmd_valid_i,
  input logic [N_PORTS*3-1:0] cmd_op_i,
  input logic [N_PORTS-1:0]   cmd_ready_o,
  input logic                 rsp_valid_o,
  input logic                 lock_held_q,
  input logic [IW-1:0]        lock_owner_q,
  input logic [N_PORTS-1:0]   wb_empty
);
  logic ld_acc;
  always_comb begin
    ld_acc = 1'b0;
    for (int p = 0; p < N_PORTS; p++)
      if (cmd_ready_o[p] && cmd_op_i[3*p +: 3] == 3'd0) ld_acc = 1'b1;
  end

  p_one_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_ready_o));
  p_ready_needs_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o & ~cmd_valid_i) == '0);
  p_rsp_follows_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_acc |=> rsp_valid_o);
  p_no_spurious_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_acc |=> !rsp_valid_o);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    p_fence_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_ready_o[g] && cmd_op_i[3*g +: 3] == 3'd2) |-> wb_empty[g]);
    p_lock_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_ready_o[g] && cmd_op_i[3*g +: 3] == 3'd5) |=> (lock_held_q && lock_owner_q == IW'(g)));
    p_unlock_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_ready_o[g] && cmd_op_i[3*g +: 3] == 3'd6) |-> (lock_held_q && lock_owner_q == IW'(g) && wb_empty[g]));
    p_load_unblocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_ready_o[g] && cmd_op_i[3*g +: 3] == 3'd0) |-> (!lock_held_q || lock_owner_q == IW'(g)));
  end
endmodule

bind tso_mem_sub tso_mem_chk #(.N_PORTS(N_PORTS), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .lock_held_q (lock_held_q),
  .lock_owner_q(lock_owner_q),
  .wb_empty    (wb_empty)
);

// File: tb/sim_tso_mem_sub.sv
module sim_tso_mem_sub;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] v = '0, den = '0, rdy;
  logic [2:0] op [2];
  logic [1:0] ad [2];
  logic [7:0] dt [2];
  logic       rv;
  logic [0:0] rp;
  logic [7:0] rd;
  logic [7:0] sh [4];
  int errors = 0, checks = 0;

  tso_mem_sub u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v),
    .cmd_op_i({op[1], op[0]}), .cmd_addr_i({ad[1], ad[0]}), .cmd_data_i({dt[1], dt[0]}),
    .cmd_ready_o(rdy), .drain_en_i(den),
    .rsp_valid_o(rv), .rsp_port_o(rp), .rsp_data_o(rd));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int p, input logic [2:0] o, input logic [1:0] a, input logic [7:0] d,
                       input int maxw, output logic ok, output int waited, output logic [7:0] data,
                       output logic rvs, output logic rps);
    @(negedge clk);
    op[p] = o; ad[p] = a; dt[p] = d; v[p] = 1'b1;
    ok = 1'b0; waited = 0;
    forever begin
      #1;
      if (rdy[p]) begin ok = 1'b1; break; end
      if (waited >= maxw) break;
      waited++;
      @(negedge clk);
    end
    if (ok) begin
      @(posedge clk);
      @(negedge clk);
      v[p] = 1'b0;
      #1;
      rvs = rv; rps = rp[0]; data = rd;
    end else begin
      v[p] = 1'b0; rvs = 1'b0; rps = 1'b0; data = '0;
    end
  endtask

  task automatic ld_chk(input string req, input int p, input logic [1:0] a, input logic [7:0] exp);
    logic ok, rvs, rps; int w; logic [7:0] d;
    issue(p, 3'd0, a, 8'h00, 20, ok, w, d, rvs, rps);
    chk({req, " load accepted"}, ok, 1);
    chk({req, " rsp valid"}, rvs, 1);
    chk({req, " rsp port"}, rps, p);
    chk({req, " load data"}, d, exp);
  endtask

  task automatic cmd(input int p, input logic [2:0] o, input logic [1:0] a, input logic [7:0] d,
                     input int maxw, output logic ok, output int w);
    logic rvs, rps; logic [7:0] dd;
    issue(p, o, a, d, maxw, ok, w, dd, rvs, rps);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ok; int w; logic [7:0] val; logic [1:0] r1, r2, r3; int win;
    for (int i = 0; i < 2; i++) begin op[i] = 3'd0; ad[i] = '0; dt[i] = '0; end
    for (int i = 0; i < 4; i++) sh[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rsp idle", rv, 0);
    chk("R1 ready idle", rdy, 0);
    for (int a = 0; a < 4; a++) ld_chk("R1 zero mem", 0, 2'(a), 8'h00);

    // sweep: every port, every address
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 4; a++) begin
        val = 8'hA0 | 8'(p << 4) | 8'(a);
        cmd(p, 3'd1, 2'(a), val, 5, ok, w);
        chk("R2 store accepted", ok, 1);
        ld_chk("R3 own forward", p, 2'(a), val);
        ld_chk("R2 other sees memory", 1 - p, 2'(a), sh[a]);
        den[p] = 1'b1;
        cmd(p, 3'd2, 2'(a), 8'h00, 20, ok, w);
        chk("R6 fence after drain", ok, 1);
        den[p] = 1'b0;
        sh[a] = val;
        ld_chk("R5 drained value", 1 - p, 2'(a), val);
      end
    end

    // fill buffer, newest-wins forwarding, full hold-off
    cmd(0, 3'd1, 2'd0, 8'h11, 5, ok, w); chk("R2 store1", ok, 1);
    cmd(0, 3'd1, 2'd0, 8'h22, 5, ok, w); chk("R2 store2", ok, 1);
    cmd(0, 3'd1, 2'd2, 8'h99, 5, ok, w); chk("R10 full store held", ok, 0);
    ld_chk("R3 newest match", 0, 2'd0, 8'h22);
    cmd(1, 3'd1, 2'd1, 8'h33, 5, ok, w); chk("R2 store p1", ok, 1);
    ld_chk("R2 cross load p0", 0, 2'd1, sh[1]);
    ld_chk("R2 cross load p1", 1, 2'd0, sh[0]);
    cmd(0, 3'd2, 2'd0, 8'h00, 4, ok, w); chk("R6 fence held", ok, 0);
    den[0] = 1'b1;
    cmd(0, 3'd2, 2'd0, 8'h00, 20, ok, w); chk("R6 fence done", ok, 1);
    den[0] = 1'b0;
    sh[0] = 8'h22;
    ld_chk("R5 oldest first", 1, 2'd0, 8'h22);

    // no-op fences with a non-empty buffer
    cmd(1, 3'd3, 2'd0, 8'h00, 0, ok, w); chk("R7 load fence", ok, 1);
    cmd(1, 3'd4, 2'd0, 8'h00, 0, ok, w); chk("R7 store fence", ok, 1);

    // lock
    cmd(1, 3'd5, 2'd0, 8'h00, 4, ok, w); chk("R8 lock held off", ok, 0);
    den[1] = 1'b1;
    cmd(1, 3'd5, 2'd0, 8'h00, 20, ok, w); chk("R8 lock taken", ok, 1);
    sh[1] = 8'h33;
    cmd(0, 3'd0, 2'd1, 8'h00, 4, ok, w); chk("R8 other load blocked", ok, 0);
    den[0] = 1'b1;
    cmd(0, 3'd1, 2'd3, 8'h66, 5, ok, w); chk("R2 store under lock", ok, 1);
    repeat (4) @(negedge clk);
    ld_chk("R5 drain blocked", 1, 2'd3, sh[3]);
    cmd(0, 3'd6, 2'd0, 8'h00, 4, ok, w); chk("R9 non-owner unlock", ok, 0);
    cmd(0, 3'd5, 2'd0, 8'h00, 4, ok, w); chk("R8 lock busy", ok, 0);
    cmd(1, 3'd6, 2'd0, 8'h00, 4, ok, w); chk("R9 owner unlock", ok, 1);
    repeat (3) @(negedge clk);
    sh[3] = 8'h66;
    ld_chk("R5 drain after unlock", 1, 2'd3, 8'h66);
    ld_chk("R8 load unblocked", 0, 2'd1, 8'h33);

    // round robin
    @(negedge clk);
    op[0] = 3'd3; op[1] = 3'd3; v = 2'b11;
    #1; r1 = rdy;
    chk("R11 one grant", $countones(r1), 1);
    win = r1[1] ? 1 : 0;
    @(posedge clk); @(negedge clk);
    v[win] = 1'b0;
    #1; r2 = rdy;
    chk("R11 other granted", r2[1 - win], 1);
    @(posedge clk); @(negedge clk);
    v = 2'b11;
    #1; r3 = rdy;
    chk("R11 rotation", r3[win], 1);
    chk("R11 single", $countones(r3), 1);
    @(posedge clk); @(negedge clk);
    v = 2'b00;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule